// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept, using its identifier. The receive path hands over the identifier as four bytes already packed in register layout, with byte 0 on bits 31:24 of `id_in`, together with a one-cycle `frame_valid` strobe. The block compares that identifier with a bank of eight acceptance-code bytes and eight mask bytes. One clock later it reports whether the frame is accepted and which filter matched. An accepted frame also sets a sticky receive-full flag. Only an explicit clear input resets that flag.

The same sixteen bytes can be used as two 32-bit filters, four 16-bit filters or eight 8-bit filters. A closed setting rejects every frame. The filter arrangement and the bank contents can be written only while the configuration-enable input is high, so software has to open a configuration window before it reprograms the filters.

Top module: `can_acc_filter`

## Requirements
- R1: After reset, `accept`, `rx_full` and `hit_idx` are 0, the mode is closed (code 3), and every code and mask byte is 0.
- R2: A mask bit of 1 makes its bit position a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit at the same position.
- R3: With mode code 0 (32-bit), filter 0 compares identifier bytes 0..3 with bank bytes 0..3, and filter 1 compares them with bank bytes 4..7.
- R4: With mode code 1 (16-bit), filter k (k = 0..3) compares identifier bytes 0..1 with bank bytes 2k and 2k+1. Bank bytes 0..3 give filters 0 and 1, and bank bytes 4..7 give filters 2 and 3.
- R5: With mode code 2 (8-bit), filter k (k = 0..7) compares identifier byte 0 with bank byte k.
- R6: When several filters hit, `hit_idx` reports the lowest-numbered hit.
- R7: With mode code 3 (closed), `accept` never goes high and `rx_full` is never set by a frame.
- R8: `accept` is a one-cycle pulse in the cycle after a `frame_valid` cycle with any hit. `hit_idx` updates at that same edge and holds until the next accepted frame.
- R9: `rx_full` is set by an acceptance and stays set until `rxf_clr` is asserted. If a clear and an acceptance land on the same edge, the flag ends set.
- R10: Writes to the mode and to the bank take effect only when `cfg_en` is high on the write edge. Writes at other times are ignored.
- R11: `accept` and `hit_idx` do not change in cycles without `frame_valid`, whatever `id_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Opens the configuration window |
| cfg_we | input | 1 | Bank byte write strobe |
| cfg_addr | input | 4 | Bank address: 0..7 code bytes, 8..15 mask bytes |
| cfg_wdata | input | 8 | Bank write data |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = closed |
| id_in | input | 32 | Identifier bytes 0..3, byte 0 on bits 31:24 |
| frame_valid | input | 1 | One cycle per received identifier |
| rxf_clr | input | 1 | Clears the receive-full flag |
| accept | output | 1 | Frame accepted (one-cycle pulse) |
| hit_idx | output | 3 | Lowest matching filter number |
| rx_full | output | 1 | Sticky receive-full flag |

## Verification
Every result is registered once, so `accept`, `hit_idx` and `rx_full` reflect a frame on the first clock edge after the one that sampled `frame_valid`, and a configuration write is in effect for a frame strobed on the next edge. The bench drives inputs on the falling edge, holds each strobe for exactly one rising edge, and reads the outputs on the next falling edge. That is after the single register stage and before `accept` drops again. Flag clears and ignored writes are judged in the same way, one edge after the stimulus, through a frame or the flag itself.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    MODE_W32    = 2'd0,
    MODE_W16    = 2'd1,
    MODE_W8     = 2'd2,
    MODE_CLOSED = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/can_acc_cfg.sv
module can_acc_cfg
  import can_acc_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  localparam int AW = $clog2(BANK_BYTES) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_en,
  input  logic                         cfg_we,
  input  logic [AW-1:0]                cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  input  logic                         mode_we,
  input  logic [1:0]                   mode_wdata,
  output filt_mode_e                   mode_q,
  output logic [BANK_BYTES-1:0][7:0]   code_q,
  output logic [BANK_BYTES-1:0][7:0]   mask_q
);
  localparam int IW = AW - 1;

  filt_mode_e                 mode_d;
  logic [BANK_BYTES-1:0][7:0] code_d, mask_d;
  logic                       wr_bank, wr_mode;

  assign wr_bank = cfg_en & cfg_we;
  assign wr_mode = cfg_en & mode_we;

  always_comb begin
    mode_d = mode_q;
    code_d = code_q;
    mask_d = mask_q;
    if (wr_mode) mode_d = filt_mode_e'(mode_wdata);
    if (wr_bank) begin
      if (cfg_addr[AW-1]) mask_d[cfg_addr[IW-1:0]] = cfg_wdata;
      else                code_d[cfg_addr[IW-1:0]] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CLOSED;
      code_q <= '0;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/can_acc_match.sv
module can_acc_match
  import can_acc_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  parameter int ID_BYTES   = 4
) (
  input  filt_mode_e                   mode,
  input  logic [ID_BYTES*8-1:0]        id_in,
  input  logic [BANK_BYTES-1:0][7:0]   code,
  input  logic [BANK_BYTES-1:0][7:0]   mask,
  output logic [BANK_BYTES-1:0]        hit_vec
);
  localparam int N32 = BANK_BYTES / 4;
  localparam int N16 = BANK_BYTES / 2;

  logic [ID_BYTES-1:0][7:0] id_b;
  logic [BANK_BYTES-1:0]    ok32, ok16, ok8;
  logic [N32-1:0]           h32;
  logic [N16-1:0]           h16;

  // byte 0 of the identifier sits on the top byte of id_in
  for (genvar b = 0; b < ID_BYTES; b++) begin : g_idb
    assign id_b[b] = id_in[(ID_BYTES-1-b)*8 +: 8];
  end

  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_byte
    assign ok32[i] = ~|((id_b[i % 4] ^ code[i]) & ~mask[i]);
    assign ok16[i] = ~|((id_b[i % 2] ^ code[i]) & ~mask[i]);
    assign ok8[i]  = ~|((id_b[0]     ^ code[i]) & ~mask[i]);
  end

  for (genvar f = 0; f < N32; f++) begin : g_f32
    assign h32[f] = &ok32[4*f +: 4];
  end
  for (genvar f = 0; f < N16; f++) begin : g_f16
    assign h16[f] = &ok16[2*f +: 2];
  end

  always_comb begin
    hit_vec = '0;
    unique case (mode)
      MODE_W32:    hit_vec[N32-1:0] = h32;
      MODE_W16:    hit_vec[N16-1:0] = h16;
      MODE_W8:     hit_vec          = ok8;
      MODE_CLOSED: hit_vec          = '0;
    endcase
  end
endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_acc_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  parameter int ID_BYTES   = 4,
  localparam int AW = $clog2(BANK_BYTES) + 1,
  localparam int HW = $clog2(BANK_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic                  mode_we,
  input  logic [1:0]            mode_wdata,
  input  logic [ID_BYTES*8-1:0] id_in,
  input  logic                  frame_valid,
  input  logic                  rxf_clr,
  output logic                  accept,
  output logic [HW-1:0]         hit_idx,
  output logic                  rx_full
);
  filt_mode_e                 cfg_mode;
  logic [BANK_BYTES-1:0][7:0] code_q, mask_q;
  logic [BANK_BYTES-1:0]      hit_vec;
  logic                       any_hit;
  logic [HW-1:0]              first_hit;

  logic          acc_d, acc_q, full_d, full_q;
  logic [HW-1:0] idx_d, idx_q;

  can_acc_cfg #(.BANK_BYTES(BANK_BYTES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mode_q(cfg_mode), .code_q(code_q),
    .mask_q(mask_q)
  );

  can_acc_match #(.BANK_BYTES(BANK_BYTES), .ID_BYTES(ID_BYTES)) u_match (
    .mode(cfg_mode), .id_in(id_in), .code(code_q), .mask(mask_q),
    .hit_vec(hit_vec)
  );

  can_acc_prio #(.N(BANK_BYTES)) u_prio (
    .req(hit_vec), .any(any_hit), .idx(first_hit)
  );

  always_comb begin
    acc_d  = frame_valid & any_hit;
    idx_d  = acc_d ? first_hit : idx_q;
    full_d = (full_q & ~rxf_clr) | acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end

  assign accept  = acc_q;
  assign hit_idx = idx_q;
  assign rx_full = full_q;
endmodule

// File: rtl/can_acc_chk.sv
module can_acc_chk
  import can_acc_pkg::*;
#(
  parameter int HW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          frame_valid,
  input logic          rxf_clr,
  input logic          accept,
  input logic [HW-1:0] hit_idx,
  input logic          rx_full,
  input filt_mode_e    cfg_mode
);
  AST_ACCEPT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_valid) |-> !accept); // R8

  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(hit_idx)); // R11

  AST_CLOSED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == MODE_CLOSED) |-> !accept); // R7

  AST_ACCEPT_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> rx_full); // R9

  AST_FULL_DROP_ONLY_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rxf_clr)); // R9

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> $stable(cfg_mode)); // R10
endmodule

bind can_acc_filter can_acc_chk #(.HW(HW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .frame_valid(frame_valid),
  .rxf_clr(rxf_clr), .accept(accept), .hit_idx(hit_idx), .rx_full(rx_full),
  .cfg_mode(cfg_mode)
);

// File: tb/can_acc_filter_tb.sv
module can_acc_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_we, mode_we, frame_valid, rxf_clr;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [1:0]  mode_wdata;
  logic [31:0] id_in;
  logic        accept, rx_full;
  logic [2:0]  hit_idx;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_acc_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .id_in(id_in), .frame_valid(frame_valid),
    .rxf_clr(rxf_clr), .accept(accept), .hit_idx(hit_idx), .rx_full(rx_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic en, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_en = en; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr_mode(input logic en, input logic [1:0] m);
    @(negedge clk);
    cfg_en = en; mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    cfg_en = 1'b0; mode_we = 1'b0;
  endtask

  task automatic load_bank(input logic [63:0] codes, input logic [63:0] masks);
    for (int i = 0; i < 8; i++) begin
      wr_byte(1'b1, 4'(i),     codes[63-8*i -: 8]);
      wr_byte(1'b1, 4'(8 + i), masks[63-8*i -: 8]);
    end
  endtask

  // frame strobed for one rising edge; outputs read on the following falling edge
  task automatic frame(input logic [31:0] id, input logic exp_acc,
                       input logic [2:0] exp_idx, input string tag);
    @(negedge clk);
    id_in = id; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    chk({tag, " accept"}, 32'(accept), 32'(exp_acc));
    if (exp_acc) chk({tag, " hit_idx"}, 32'(hit_idx), 32'(exp_idx));
  endtask

  task automatic clear_flag();
    @(negedge clk); rxf_clr = 1'b1;
    @(negedge clk); rxf_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 accept", 32'(accept), 0);
    chk("R1 rx_full", 32'(rx_full), 0);
    chk("R1 hit_idx", 32'(hit_idx), 0);
    frame(32'h0, 1'b0, 3'd0, "R1 R7 closed at reset");
    chk("R7 rx_full after closed frame", 32'(rx_full), 0);
  endtask

  task automatic t_w32();
    load_bank(64'h12345678_AABBCCDD, 64'h00000000_000000FF);
    wr_mode(1'b1, 2'd0);
    frame(32'h12345678, 1'b1, 3'd0, "R3 filter0");
    frame(32'hAABBCC00, 1'b1, 3'd1, "R3 filter1");
    frame(32'hAABBCCFF, 1'b1, 3'd1, "R2 masked byte");
    frame(32'h12345679, 1'b0, 3'd0, "R2 R3 one bit off");
    chk("R9 rx_full set", 32'(rx_full), 1);
  endtask

  task automatic t_w16();
    load_bank(64'h12345566_12309999, 64'h00000000_000F0000);
    wr_mode(1'b1, 2'd1);
    frame(32'h5566ABCD, 1'b1, 3'd1, "R4 filter1");
    frame(32'h12340000, 1'b1, 3'd0, "R4 R6 filters0+2");
    frame(32'h1238FFFF, 1'b1, 3'd2, "R4 R2 filter2 mask");
    frame(32'h99990000, 1'b1, 3'd3, "R4 filter3");
    frame(32'h00001234, 1'b0, 3'd0, "R4 no hit");
  endtask

  task automatic t_w8();
    load_bank(64'h01020304_05060708, 64'h00000000_000000FF);
    wr_mode(1'b1, 2'd2);
    frame(32'h03AABBCC, 1'b1, 3'd2, "R5 R6 filters2+7");
    frame(32'hF0000000, 1'b1, 3'd7, "R5 R2 masked filter7");
    frame(32'h01000000, 1'b1, 3'd0, "R5 filter0");
  endtask

  task automatic t_locked();
    wr_mode(1'b0, 2'd3);
    frame(32'h01000000, 1'b1, 3'd0, "R10 mode write ignored");
    wr_byte(1'b0, 4'd0, 8'h55);
    frame(32'h01000000, 1'b1, 3'd0, "R10 code write ignored");
  endtask

  task automatic t_idle();
    @(negedge clk);
    id_in = 32'h05000000;
    repeat (3) @(negedge clk);
    chk("R11 accept idle", 32'(accept), 0);
    chk("R11 hit_idx held", 32'(hit_idx), 0);
  endtask

  task automatic t_flag();
    clear_flag();
    chk("R9 rx_full cleared", 32'(rx_full), 0);
    @(negedge clk);
    id_in = 32'h02000000; frame_valid = 1'b1; rxf_clr = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0; rxf_clr = 1'b0;
    chk("R9 set beats clear", 32'(rx_full), 1);
    chk("R8 accept pulse", 32'(accept), 1);
    @(negedge clk);
    chk("R8 accept one cycle", 32'(accept), 0);
    chk("R8 hit_idx holds", 32'(hit_idx), 1);
  endtask

  task automatic t_closed();
    clear_flag();
    wr_mode(1'b1, 2'd3);
    frame(32'h01000000, 1'b0, 3'd0, "R7 closed rejects match");
    chk("R7 rx_full stays clear", 32'(rx_full), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; mode_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; mode_wdata = '0; id_in = '0;
    frame_valid = 1'b0; rxf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_w32();
    t_w16();
    t_w8();
    t_locked();
    t_idle();
    t_flag();
    t_closed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule